// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block turns a six-byte window of instruction memory, taken at the current program counter, into the fields of one instruction of a compact 32-bit instruction set. Instructions are 1, 2, 5 or 6 bytes long. The leading byte selects the instruction class. That class sets the length, whether a register-specifier byte follows, and whether a 32-bit constant is present. When a constant is present, it starts either at the second or at the third byte of the window.

The decoding itself is combinational. It is split into a format decoder that works on the leading byte, a field extractor that works on the rest of the window, and a next-address adder. A registered stage at the top captures one decoded instruction for each cycle in which `in_valid` is high, and holds its result otherwise.

Window layout: byte k of the window (k = 0..5, byte 0 at the program counter) sits on `fetch_win[8k+7:8k]`.

Top module: `fetch_decoder`

## Requirements
- R1: The upper nibble of byte 0 appears on `op_code` and the lower nibble on `op_fn`, for every byte 0 value.
- R2: `pc_next` equals `fetch_pc` plus the instruction length, modulo 2^32. Lengths by class code: 0x0, 0x1 and 0x9 take 1 byte; 0x2, 0x6, 0xA and 0xB take 2 bytes; 0x7 and 0x8 take 5 bytes; 0x3, 0x4 and 0x5 take 6 bytes.
- R3: For classes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB, `reg_a` is the upper nibble and `reg_b` the lower nibble of byte 1, passed through unchanged.
- R4: For classes 0x0, 0x1, 0x7, 0x8 and 0x9, which have no register byte, `reg_a` and `reg_b` are both 4'h8.
- R5: For classes 0x3, 0x4 and 0x5, `imm` is bytes 2..5 assembled little-endian, with byte 2 as the least significant byte.
- R6: For classes 0x7 and 0x8, `imm` is bytes 1..4 assembled little-endian, with byte 1 as the least significant byte. Byte 5 has no effect.
- R7: For classes 0x0, 0x1, 0x2, 0x6, 0x9, 0xA and 0xB, `imm` is zero whatever the window holds.
- R8: A class code above 0xB sets `illegal`. Such an instruction is treated as 1 byte long, with `reg_a` = `reg_b` = 4'h8 and `imm` = 0.
- R9: `illegal` is also set by a function code that is out of range: above 3 for class 0x6, above 6 for class 0x7, or non-zero for any other class. Otherwise `illegal` is 0.
- R10: The outputs update at the clock edge that samples `in_valid` high, and `out_valid` follows `in_valid` one cycle later. While `in_valid` is low, all field outputs hold their last value.
- R11: While `rst_n` is low, `out_valid`, `illegal`, `op_code`, `op_fn`, `reg_a`, `reg_b`, `imm` and `pc_next` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and PC are valid this cycle |
| fetch_pc | input | 32 | Address of byte 0 of the window |
| fetch_win | input | 48 | Six instruction bytes, byte 0 in the low bits |
| out_valid | output | 1 | Registered outputs hold a fresh decode |
| op_code | output | 4 | Class code (upper nibble of byte 0) |
| op_fn | output | 4 | Function code (lower nibble of byte 0) |
| reg_a | output | 4 | First register specifier, or 4'h8 |
| reg_b | output | 4 | Second register specifier, or 4'h8 |
| imm | output | 32 | Constant word, or zero |
| pc_next | output | 32 | Address of the next sequential instruction |
| illegal | output | 1 | Class or function code out of range |

## Verification
The hardest case to provoke is a window whose bytes beyond the instruction's own length carry values that would alter the result if they were wrongly picked up, in particular byte 5 for the 5-byte classes and byte 1 for the single-byte classes. The stimulus therefore fills every unused byte with distinct non-zero patterns, so a wrong byte offset or a missing zero-fill shows up as a visible change in `imm` or in the register fields. The next-address carry is pushed across the 32-bit boundary by placing a 6-byte instruction two bytes below the top of the address space.

// File: rtl/fd_pkg.sv
package fd_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_MOVRR = 4'h2,
        OP_MOVIR = 4'h3,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } opc_e;

    localparam logic [3:0] REG_NONE = 4'h8;

    typedef struct packed {
        logic [3:0] len;        // bytes occupied by the instruction
        logic       has_reg;    // register byte follows byte 0
        logic       has_const;  // constant word present
        logic       const_at1;  // constant starts at byte 1 (else byte 2)
        logic       legal;      // class and function code in range
    } fmt_t;

endpackage

// File: rtl/fd_format_decode.sv
module fd_format_decode
    import fd_pkg::*;
#(
    parameter int CBYTES     = 4,
    parameter int ALU_FN_MAX = 3,
    parameter int JMP_FN_MAX = 6
) (
    input  logic [3:0] opc,
    input  logic [3:0] fn,
    output fmt_t       fmt
);
    localparam logic [3:0] LEN_JMP  = 4'(1 + CBYTES);
    localparam logic [3:0] LEN_FULL = 4'(2 + CBYTES);

    logic fn_zero;
    assign fn_zero = (fn == 4'h0);

    always_comb begin
        fmt = '{len: 4'd1, has_reg: 1'b0, has_const: 1'b0,
                const_at1: 1'b0, legal: 1'b0};
        unique case (opc)
            OP_NOP, OP_HALT, OP_RET: begin
                fmt.len   = 4'd1;
                fmt.legal = fn_zero;
            end
            OP_MOVRR, OP_PUSH, OP_POP: begin
                fmt.len     = 4'd2;
                fmt.has_reg = 1'b1;
                fmt.legal   = fn_zero;
            end
            OP_ALU: begin
                fmt.len     = 4'd2;
                fmt.has_reg = 1'b1;
                fmt.legal   = (32'(fn) <= ALU_FN_MAX);
            end
            OP_MOVIR, OP_STORE, OP_LOAD: begin
                fmt.len       = LEN_FULL;
                fmt.has_reg   = 1'b1;
                fmt.has_const = 1'b1;
                fmt.legal     = fn_zero;
            end
            OP_JUMP: begin
                fmt.len       = LEN_JMP;
                fmt.has_const = 1'b1;
                fmt.const_at1 = 1'b1;
                fmt.legal     = (32'(fn) <= JMP_FN_MAX);
            end
            OP_CALL: begin
                fmt.len       = LEN_JMP;
                fmt.has_const = 1'b1;
                fmt.const_at1 = 1'b1;
                fmt.legal     = fn_zero;
            end
            default: begin
                fmt.len   = 4'd1;
                fmt.legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fd_field_extract.sv
module fd_field_extract
    import fd_pkg::*;
#(
    parameter int CBYTES = 4,
    localparam int WBYTES = CBYTES + 2,
    localparam int CW     = 8 * CBYTES
) (
    input  logic [8*WBYTES-1:0] win,
    input  fmt_t                fmt,
    output logic [3:0]          ra,
    output logic [3:0]          rb,
    output logic [CW-1:0]       cval
);
    logic [CW-1:0] c_from1;
    logic [CW-1:0] c_from2;
    logic [7:0]    reg_byte;

    // little-endian assembly: lowest-addressed byte to the least significant lane
    for (genvar k = 0; k < CBYTES; k++) begin : g_lane
        assign c_from1[8*k +: 8] = win[8*(k+1) +: 8];
        assign c_from2[8*k +: 8] = win[8*(k+2) +: 8];
    end

    assign reg_byte = win[15:8];

    always_comb begin
        if (fmt.has_reg) begin
            ra = reg_byte[7:4];
            rb = reg_byte[3:0];
        end else begin
            ra = REG_NONE;
            rb = REG_NONE;
        end
        if (!fmt.has_const) begin
            cval = '0;
        end else if (fmt.const_at1) begin
            cval = c_from1;
        end else begin
            cval = c_from2;
        end
    end

    logic unused_low;
    assign unused_low = ^win[7:0];
endmodule

// File: rtl/fd_next_pc.sv
module fd_next_pc #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic [3:0]    len,
    output logic [AW-1:0] pc_next
);
    assign pc_next = pc + {{(AW-4){1'b0}}, len};
endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
    import fd_pkg::*;
#(
    parameter int AW     = 32,
    parameter int CBYTES = 4,
    localparam int WBYTES = CBYTES + 2,
    localparam int CW     = 8 * CBYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [AW-1:0]       fetch_pc,
    input  logic [8*WBYTES-1:0] fetch_win,
    output logic                out_valid,
    output logic [3:0]          op_code,
    output logic [3:0]          op_fn,
    output logic [3:0]          reg_a,
    output logic [3:0]          reg_b,
    output logic [CW-1:0]       imm,
    output logic [AW-1:0]       pc_next,
    output logic                illegal
);
    logic [3:0]    d_opc;
    logic [3:0]    d_fn;
    fmt_t          d_fmt;
    logic [3:0]    d_ra;
    logic [3:0]    d_rb;
    logic [CW-1:0] d_cval;
    logic [AW-1:0] d_next;

    assign d_opc = fetch_win[7:4];
    assign d_fn  = fetch_win[3:0];

    fd_format_decode #(.CBYTES(CBYTES)) u_fmt (
        .opc (d_opc),
        .fn  (d_fn),
        .fmt (d_fmt)
    );

    fd_field_extract #(.CBYTES(CBYTES)) u_fld (
        .win  (fetch_win),
        .fmt  (d_fmt),
        .ra   (d_ra),
        .rb   (d_rb),
        .cval (d_cval)
    );

    fd_next_pc #(.AW(AW)) u_npc (
        .pc      (fetch_pc),
        .len     (d_fmt.len),
        .pc_next (d_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            op_code   <= '0;
            op_fn     <= '0;
            reg_a     <= '0;
            reg_b     <= '0;
            imm       <= '0;
            pc_next   <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                op_code <= d_opc;
                op_fn   <= d_fn;
                reg_a   <= d_ra;
                reg_b   <= d_rb;
                imm     <= d_cval;
                pc_next <= d_next;
                illegal <= ~d_fmt.legal;
            end
        end
    end
endmodule

// File: rtl/fetch_decoder_chk.sv
module fetch_decoder_chk #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [AW-1:0] fetch_pc,
    input logic          out_valid,
    input logic [3:0]    op_code,
    input logic [3:0]    op_fn,
    input logic [3:0]    reg_a,
    input logic [3:0]    reg_b,
    input logic [CW-1:0] imm,
    input logic [AW-1:0] pc_next,
    input logic          illegal
);
    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pc_next) && $stable(imm) && $stable(illegal)));
    a_r2_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (op_code == 4'h0 || op_code == 4'h1 || op_code == 4'h9
                       || op_code > 4'hB))
        |-> pc_next == $past(fetch_pc) + 1);
    a_r4_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (op_code == 4'h0 || op_code == 4'h1 || op_code == 4'h7
                       || op_code == 4'h8 || op_code == 4'h9))
        |-> (reg_a == 4'h8 && reg_b == 4'h8));
    a_r7_no_const: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (op_code == 4'h0 || op_code == 4'h1 || op_code == 4'h2
                       || op_code == 4'h6 || op_code == 4'h9
                       || op_code == 4'hA || op_code == 4'hB))
        |-> imm == '0);
    a_r8_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_code > 4'hB) |-> (illegal && imm == '0));
    a_r9_alu_fn: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_code == 4'h6) |-> (illegal == (op_fn > 4'h3)));
endmodule

bind fetch_decoder fetch_decoder_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fetch_pc  (fetch_pc),
    .out_valid (out_valid),
    .op_code   (op_code),
    .op_fn     (op_fn),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .imm       (imm),
    .pc_next   (pc_next),
    .illegal   (illegal)
);

// File: tb/fetch_decoder_tb.sv
module fetch_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [47:0] fetch_win = '0;
    logic        out_valid;
    logic [3:0]  op_code, op_fn, reg_a, reg_b;
    logic [31:0] imm, pc_next;
    logic        illegal;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    fetch_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .fetch_pc(fetch_pc), .fetch_win(fetch_win),
        .out_valid(out_valid), .op_code(op_code), .op_fn(op_fn),
        .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .pc_next(pc_next),
        .illegal(illegal)
    );

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // apply one window, let it be captured, then sample between edges
    task automatic decode(input logic [31:0] pc, input logic [47:0] w);
        @(negedge clk);
        fetch_pc  = pc;
        fetch_win = w;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic expect_all(input string tag, input logic [3:0] oc, fn, ra, rb,
                              input logic [31:0] c, np, input logic il);
        chk({tag, " R10 out_valid"}, 32'(out_valid), 32'd1);
        chk({tag, " R1 op_code"}, 32'(op_code), 32'(oc));
        chk({tag, " R1 op_fn"}, 32'(op_fn), 32'(fn));
        chk({tag, " R3/R4 reg_a"}, 32'(reg_a), 32'(ra));
        chk({tag, " R3/R4 reg_b"}, 32'(reg_b), 32'(rb));
        chk({tag, " R5/R6/R7 imm"}, imm, c);
        chk({tag, " R2 pc_next"}, pc_next, np);
        chk({tag, " R8/R9 illegal"}, 32'(illegal), 32'(il));
    endtask

    task automatic t_reset;
        chk("R11 out_valid", 32'(out_valid), 0);
        chk("R11 pc_next", pc_next, 0);
        chk("R11 imm", imm, 0);
        chk("R11 illegal", 32'(illegal), 0);
        chk("R11 regs", {24'd0, reg_a, reg_b}, 0);
    endtask

    task automatic t_single_byte;
        decode(32'h100, mk(8'h00, 8'h5A, 8'hA5, 8'h11, 8'h22, 8'h33));
        expect_all("nop R4 R7", 4'h0, 4'h0, 4'h8, 4'h8, 0, 32'h101, 0);
        decode(32'h200, mk(8'h10, 8'h37, 8'h99, 8'h88, 8'h77, 8'h66));
        expect_all("halt R2", 4'h1, 4'h0, 4'h8, 4'h8, 0, 32'h201, 0);
        decode(32'h300, mk(8'h90, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF));
        expect_all("ret R7", 4'h9, 4'h0, 4'h8, 4'h8, 0, 32'h301, 0);
    endtask

    task automatic t_reg_byte;
        decode(32'h400, mk(8'h62, 8'h37, 8'hDE, 8'hAD, 8'hBE, 8'hEF));
        expect_all("alu R3", 4'h6, 4'h2, 4'h3, 4'h7, 0, 32'h402, 0);
        decode(32'h410, mk(8'h20, 8'h15, 8'h44, 8'h44, 8'h44, 8'h44));
        expect_all("movrr R3", 4'h2, 4'h0, 4'h1, 4'h5, 0, 32'h412, 0);
        decode(32'h420, mk(8'hA0, 8'h48, 8'h12, 8'h34, 8'h56, 8'h78));
        expect_all("push R3", 4'hA, 4'h0, 4'h4, 4'h8, 0, 32'h422, 0);
        decode(32'h430, mk(8'hB0, 8'hC8, 8'h12, 8'h34, 8'h56, 8'h78));
        expect_all("pop R7", 4'hB, 4'h0, 4'hC, 4'h8, 0, 32'h432, 0);
    endtask

    task automatic t_const_at2;
        decode(32'h500, mk(8'h30, 8'h82, 8'h78, 8'h56, 8'h34, 8'h12));
        expect_all("movir R5", 4'h3, 4'h0, 4'h8, 4'h2, 32'h12345678, 32'h506, 0);
        decode(32'h510, mk(8'h40, 8'h16, 8'h01, 8'h00, 8'h00, 8'h80));
        expect_all("store R5", 4'h4, 4'h0, 4'h1, 4'h6, 32'h80000001, 32'h516, 0);
        decode(32'h520, mk(8'h50, 8'h73, 8'hEF, 8'hCD, 8'hAB, 8'h89));
        expect_all("load R5", 4'h5, 4'h0, 4'h7, 4'h3, 32'h89ABCDEF, 32'h526, 0);
    endtask

    task automatic t_const_at1;
        decode(32'h600, mk(8'h73, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 8'h5C));
        expect_all("jump R6", 4'h7, 4'h3, 4'h8, 4'h8, 32'hDEADBEEF, 32'h605, 0);
        decode(32'h700, mk(8'h80, 8'h00, 8'h10, 8'h00, 8'h00, 8'hFF));
        expect_all("call R6", 4'h8, 4'h0, 4'h8, 4'h8, 32'h00001000, 32'h705, 0);
    endtask

    task automatic t_bad_class;
        decode(32'h800, mk(8'hC0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A));
        expect_all("class C R8", 4'hC, 4'h0, 4'h8, 4'h8, 0, 32'h801, 1);
        decode(32'h810, mk(8'hF5, 8'hAB, 8'hCD, 8'hEF, 8'h01, 8'h23));
        expect_all("class F R8", 4'hF, 4'h5, 4'h8, 4'h8, 0, 32'h811, 1);
    endtask

    task automatic t_bad_fn;
        decode(32'h900, mk(8'h63, 8'h12, 0, 0, 0, 0));
        chk("R9 alu fn 3 legal", 32'(illegal), 0);
        decode(32'h900, mk(8'h64, 8'h12, 0, 0, 0, 0));
        chk("R9 alu fn 4 illegal", 32'(illegal), 1);
        decode(32'h900, mk(8'h76, 0, 0, 0, 0, 0));
        chk("R9 jump fn 6 legal", 32'(illegal), 0);
        decode(32'h900, mk(8'h77, 0, 0, 0, 0, 0));
        chk("R9 jump fn 7 illegal", 32'(illegal), 1);
        decode(32'h900, mk(8'h11, 0, 0, 0, 0, 0));
        chk("R9 halt fn 1 illegal", 32'(illegal), 1);
        decode(32'h900, mk(8'h31, 8'h81, 0, 0, 0, 0));
        chk("R9 movir fn 1 illegal", 32'(illegal), 1);
        chk("R9 movir fn 1 pc_next", pc_next, 32'h906);
    endtask

    task automatic t_wrap;
        decode(32'hFFFF_FFFE, mk(8'h30, 8'h81, 8'h04, 8'h03, 8'h02, 8'h01));
        chk("R2 wrap pc_next", pc_next, 32'h0000_0004);
        chk("R5 wrap imm", imm, 32'h01020304);
    endtask

    task automatic t_hold;
        decode(32'hA00, mk(8'h80, 8'h44, 8'h33, 8'h22, 8'h11, 8'h00));
        @(negedge clk);
        fetch_pc  = 32'hBEEF;
        fetch_win = mk(8'h62, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);
        @(negedge clk);
        @(negedge clk);
        chk("R10 idle out_valid", 32'(out_valid), 0);
        chk("R10 hold pc_next", pc_next, 32'hA05);
        chk("R10 hold imm", imm, 32'h11223344);
        chk("R10 hold op_code", 32'(op_code), 32'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_single_byte;
        t_reg_byte;
        t_const_at2;
        t_const_at1;
        t_bad_class;
        t_bad_fn;
        t_wrap;
        t_hold;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule